// File: doc/BRIEF.md
# Request-to-Send Output Controller

This block owns the request-to-send line of one serial channel. A single internal flag decides the line level: while the flag is set the pin is driven low, which asks the far end to send, and while it is clear the pin sits high. Software moves the flag in two ways. It can write a mask to the output-port set register or to the output-port reset register. It can also issue an on or off code through the channel command register.

Two optional hardware sources act on the same flag. With receiver flow control enabled, the flag drops when the receive FIFO fills and rises again as soon as the FIFO leaves the full state. With transmitter flow control enabled, the flag drops when the last queued character has completely left the shifter. If a set source and a clear source fire in the same clock, the clear wins. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `rts_ctrl`

## Requirements
- R1: After reset, and until the first flag event, `rts_bit` is 0 and `rts_n` is 1.
- R2: `rts_n` is always the inverse of `rts_bit`.
- R3: A clock with `opset_we`=1 and `opset_data[RTS_BIT]`=1 sets the flag on that edge, unless a clear source is also active.
- R4: A clock with `opclr_we`=1 and `opclr_data[RTS_BIT]`=1 clears the flag on that edge.
- R5: A write to either port register whose bit `RTS_BIT` is 0 leaves the flag unchanged, whatever its other bits hold.
- R6: With `cmd_we`=1, code 4'h8 (`CMD_ON`) sets the flag, code 4'h9 (`CMD_OFF`) clears it, and every other code leaves it unchanged.
- R7: With `rx_auto_en`=1, a 0→1 change of `rx_full` between consecutive clocks clears the flag and a 1→0 change sets it. With `rx_auto_en`=0 these changes have no effect.
- R8: With `tx_auto_en`=1, a clock with `tx_last_done`=1 clears the flag. With `tx_auto_en`=0 the pulse has no effect.
- R9: When any set source and any clear source are active in the same clock, the flag is 0 after that edge.
- R10: In a clock with no active source, the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opset_we | input | 1 | Output-port set register write strobe |
| opset_data | input | PORT_W | Mask written to the set register |
| opclr_we | input | 1 | Output-port reset register write strobe |
| opclr_data | input | PORT_W | Mask written to the reset register |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | CMD_W | Command code |
| rx_full | input | 1 | Receive FIFO full status level |
| tx_last_done | input | 1 | One-clock pulse: last character has left the shifter |
| rx_auto_en | input | 1 | Enables receiver flow control of the flag |
| tx_auto_en | input | 1 | Enables transmitter flow control of the flag |
| rts_n | output | 1 | Active-low request-to-send pin |
| rts_bit | output | 1 | Internal flag, readable |

## Verification
The whole state of the block is the flag plus the remembered FIFO-full level, and both reach the ports within one clock. A wrong flag value shows on `rts_bit` and `rts_n` right after the edge that produced it. A wrong remembered FIFO level shows one edge later, as a missed or spurious flag change when `rx_full` moves with receiver flow control on. The sweeps drive every combination of strobes, mask bit, command class, flow enables and FIFO level, in two orders, from varying flag states. Because of that, a single-edge fault in any source or in the set/clear priority is seen on the next sample.

// File: rtl/rts_pkg.sv
package rts_pkg;

  // One pair of requests produced by a source group for the flag register.
  typedef struct packed {
    logic set;
    logic clr;
  } rts_req_t;

  function automatic rts_req_t rts_merge(input rts_req_t a, input rts_req_t b);
    rts_req_t m;
    m.set = a.set | b.set;
    m.clr = a.clr | b.clr;
    return m;
  endfunction

endpackage

// File: rtl/rts_rst_sync.sv
module rts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= 1'b0;
          else         chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/rts_sw_decode.sv
module rts_sw_decode
  import rts_pkg::*;
#(
  parameter int          PORT_W  = 8,
  parameter int          RTS_BIT = 0,
  parameter int          CMD_W   = 4,
  parameter logic [3:0]  CMD_ON  = 4'h8,
  parameter logic [3:0]  CMD_OFF = 4'h9
) (
  input  logic              opset_we,
  input  logic [PORT_W-1:0] opset_data,
  input  logic              opclr_we,
  input  logic [PORT_W-1:0] opclr_data,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  output rts_req_t          sw_req
);

  localparam logic [CMD_W-1:0] ON_CODE  = CMD_W'(CMD_ON);
  localparam logic [CMD_W-1:0] OFF_CODE = CMD_W'(CMD_OFF);

  logic port_set, port_clr, cmd_set, cmd_clr;

  always_comb begin
    port_set   = opset_we & opset_data[RTS_BIT];
    port_clr   = opclr_we & opclr_data[RTS_BIT];
    cmd_set    = cmd_we & (cmd_code == ON_CODE);
    cmd_clr    = cmd_we & (cmd_code == OFF_CODE);
    sw_req.set = port_set | cmd_set;
    sw_req.clr = port_clr | cmd_clr;
  end

endmodule

// File: rtl/rts_flow_events.sv
module rts_flow_events
  import rts_pkg::*;
(
  input  logic     clk,
  input  logic     srst_n,
  input  logic     rx_full,
  input  logic     tx_last_done,
  input  logic     rx_auto_en,
  input  logic     tx_auto_en,
  output rts_req_t hw_req
);

  logic full_q, full_d;
  logic went_full, went_room;

  always_comb begin
    full_d     = rx_full;
    went_full  = rx_full & ~full_q;
    went_room  = ~rx_full & full_q;
    hw_req.set = rx_auto_en & went_room;
    hw_req.clr = (rx_auto_en & went_full) | (tx_auto_en & tx_last_done);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) full_q <= 1'b0;
    else         full_q <= full_d;
  end

  // R7: with receiver flow control off, no FIFO transition asks for a change
  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !rx_auto_en |-> !hw_req.set);

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import rts_pkg::*;
#(
  parameter int          PORT_W      = 8,
  parameter int          RTS_BIT     = 0,
  parameter int          CMD_W       = 4,
  parameter logic [3:0]  CMD_ON      = 4'h8,
  parameter logic [3:0]  CMD_OFF     = 4'h9,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opset_we,
  input  logic [PORT_W-1:0] opset_data,
  input  logic              opclr_we,
  input  logic [PORT_W-1:0] opclr_data,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              rx_full,
  input  logic              tx_last_done,
  input  logic              rx_auto_en,
  input  logic              tx_auto_en,
  output logic              rts_n,
  output logic              rts_bit
);

  localparam logic [CMD_W-1:0] OFF_CODE = CMD_W'(CMD_OFF);

  logic     srst_n;
  rts_req_t sw_req, hw_req, all_req;
  logic     flag_q, flag_d, flag_en;

  rts_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rts_sw_decode #(
    .PORT_W (PORT_W), .RTS_BIT (RTS_BIT), .CMD_W (CMD_W),
    .CMD_ON (CMD_ON), .CMD_OFF (CMD_OFF)
  ) u_sw (
    .opset_we   (opset_we),
    .opset_data (opset_data),
    .opclr_we   (opclr_we),
    .opclr_data (opclr_data),
    .cmd_we     (cmd_we),
    .cmd_code   (cmd_code),
    .sw_req     (sw_req)
  );

  rts_flow_events u_hw (
    .clk          (clk),
    .srst_n       (srst_n),
    .rx_full      (rx_full),
    .tx_last_done (tx_last_done),
    .rx_auto_en   (rx_auto_en),
    .tx_auto_en   (tx_auto_en),
    .hw_req       (hw_req)
  );

  // Next state: clear has priority over set
  always_comb begin
    all_req = rts_merge(sw_req, hw_req);
    flag_en = all_req.set | all_req.clr;
    flag_d  = all_req.set & ~all_req.clr;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign rts_bit = flag_q;
  assign rts_n   = ~flag_q;

  // R4 and R9: a reset-register write with the flag bit always leaves it clear
  p_port_clr_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (opclr_we && opclr_data[RTS_BIT]) |=> !rts_bit);

  // R6: the off command always leaves the flag clear
  p_cmd_off_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_we && cmd_code == OFF_CODE) |=> !rts_bit);

  // R8: end of transmission with transmitter control drops the request
  p_tx_done_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_auto_en && tx_last_done) |=> !rts_bit);

  // R7: FIFO becoming full with receiver control drops the request
  p_rx_full_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_auto_en && $rose(rx_full)) |=> !rts_bit);

  // R3: a lone set write raises the flag
  p_port_set_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (opset_we && opset_data[RTS_BIT] && !opclr_we && !cmd_we &&
     !tx_last_done && !rx_auto_en) |=> rts_bit);

  // R10: with every source idle the flag holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (!opset_we && !opclr_we && !cmd_we && !tx_last_done && !rx_auto_en)
    |=> $stable(rts_bit));

endmodule

// File: tb/rts_ctrl_test.sv
module rts_ctrl_test;

  localparam int PORT_W  = 8;
  localparam int RTS_BIT = 0;
  localparam int CMD_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              opset_we, opclr_we, cmd_we;
  logic [PORT_W-1:0] opset_data, opclr_data;
  logic [CMD_W-1:0]  cmd_code;
  logic              rx_full, tx_last_done, rx_auto_en, tx_auto_en;
  logic              rts_n, rts_bit;

  int  total = 0;
  int  bad   = 0;
  logic exp_bit;
  logic prev_full;

  always #4 clk = ~clk;

  rts_ctrl uut (
    .clk (clk), .rst_n (rst_n),
    .opset_we (opset_we), .opset_data (opset_data),
    .opclr_we (opclr_we), .opclr_data (opclr_data),
    .cmd_we (cmd_we), .cmd_code (cmd_code),
    .rx_full (rx_full), .tx_last_done (tx_last_done),
    .rx_auto_en (rx_auto_en), .tx_auto_en (tx_auto_en),
    .rts_n (rts_n), .rts_bit (rts_bit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    opset_we = 0; opclr_we = 0; cmd_we = 0;
    opset_data = '0; opclr_data = '0; cmd_code = '0;
    tx_last_done = 0; tx_auto_en = 0; rx_auto_en = 0;
  endtask

  // Applies the currently driven inputs for one edge, updates the model, checks.
  task automatic step(input string req);
    logic s, c;
    s = (opset_we & opset_data[RTS_BIT]) | (cmd_we & (cmd_code == 4'h8)) |
        (rx_auto_en & prev_full & ~rx_full);
    c = (opclr_we & opclr_data[RTS_BIT]) | (cmd_we & (cmd_code == 4'h9)) |
        (rx_auto_en & rx_full & ~prev_full) | (tx_auto_en & tx_last_done);
    if (c)      exp_bit = 1'b0;
    else if (s) exp_bit = 1'b1;
    prev_full = rx_full;
    @(posedge clk);
    #2;
    check(req, rts_bit, exp_bit);
    check("R2", rts_n, ~rts_bit);
    @(negedge clk);
  endtask

  task automatic sweep(input bit reverse);
    for (int k = 0; k < 1536; k++) begin
      int i;
      int cls;
      string tag;
      i = reverse ? (1535 - k) : k;
      idle_inputs();
      opset_we   = i[0];
      opset_data = {PORT_W{i[9]}};
      opset_data[RTS_BIT] = i[1];
      opclr_we   = i[2];
      opclr_data = {PORT_W{~i[9]}};
      opclr_data[RTS_BIT] = i[3];
      cmd_we     = i[4];
      tx_last_done = i[5];
      tx_auto_en = i[6];
      rx_auto_en = i[7];
      rx_full    = i[8];
      cls = (i >> 9) % 3;
      cmd_code   = (cls == 0) ? 4'h8 : (cls == 1) ? 4'h9 : 4'(3 + (i % 5));
      if ((opset_we && !opset_data[RTS_BIT]) || (opclr_we && !opclr_data[RTS_BIT]))
        tag = "R5";
      else if (rx_auto_en && (rx_full != prev_full)) tag = "R7";
      else if (tx_last_done) tag = "R8";
      else if (cmd_we) tag = "R6";
      else tag = "R9";
      step(tag);
    end
  endtask

  initial begin
    idle_inputs();
    rx_full = 0; prev_full = 0; exp_bit = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", rts_bit, 1'b0);
    check("R1", rts_n, 1'b1);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1", rts_bit, 1'b0);
    check("R1", rts_n, 1'b1);

    // R3 set through port register
    opset_we = 1; opset_data = 8'h01; step("R3");
    idle_inputs(); step("R10");
    // R5 zero bit written to reset register, other bits set
    opclr_we = 1; opclr_data = 8'hFE; step("R5");
    // R4 clear through port register
    idle_inputs(); opclr_we = 1; opclr_data = 8'h01; step("R4");
    // R5 zero bit written to set register
    idle_inputs(); opset_we = 1; opset_data = 8'hFE; step("R5");
    // R6 commands
    idle_inputs(); cmd_we = 1; cmd_code = 4'h8; step("R6");
    cmd_code = 4'h3; step("R6");
    cmd_code = 4'h9; step("R6");
    // R9 set and clear together
    idle_inputs(); opset_we = 1; opset_data = 8'h01; cmd_we = 1; cmd_code = 4'h9;
    step("R9");
    // R7 receiver flow control
    idle_inputs(); cmd_we = 1; cmd_code = 4'h8; step("R6");
    idle_inputs(); rx_auto_en = 1; rx_full = 1; step("R7");
    rx_full = 0; step("R7");
    rx_auto_en = 0; rx_full = 1; step("R7");
    rx_full = 0; step("R7");
    // R8 transmitter flow control
    idle_inputs(); tx_last_done = 1; step("R8");
    tx_auto_en = 1; step("R8");
    idle_inputs(); step("R10");

    sweep(1'b0);
    sweep(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule